// File: doc/BRIEF.md
# Execute-Stage Register Hazard Tracker

This block decides, each cycle, whether the instruction in decode of a small in-order pipeline may read its source registers. The pipeline has a decode stage, an execute stage that can take more than one cycle, and a write-back port. The tracker keeps one pending-write flag for the instruction that occupies execute. When a decode source names the register that execute still owes, the tracker stalls decode. When the value a source needs is on the write-back path in the current cycle, and no younger pending write covers it, the tracker selects that path as a forward.

The flag is cleared only by the execute instruction's own result. A write-back that arrives during the first cycle an instruction spends in execute belongs to an older instruction, because execute needs at least one cycle to produce a result. This holds even when the older instruction targets the same register. Without the rule, two back-to-back writes to one register would let a reader take the older, stale value.

Top module: `hazard_ctl`

## Requirements
- R1: While reset (rst_n low, asynchronous) is asserted, the pending flag and first-cycle marker are cleared; stall, fwd_rs1 and fwd_rs2 are low.
- R2: When ex_enter is high with dec_wr high and dec_rd non-zero, the pending flag is set from the next cycle. While it is set, a non-zero decode source equal to that destination drives stall high.
- R3: An instruction that enters execute with dec_wr low, or with dec_rd equal to 0, sets no pending flag, and no later decode source stalls because of it.
- R4: A source register ID of 0 never causes stall and never asserts its forward select.
- R5: A write-back whose ID matches the execute destination during the first cycle after ex_enter does not clear the flag. Stall stays high for a matching source and that source is not forwarded.
- R6: A matching write-back in the second or later execute cycle drops stall in that same cycle and asserts the forward select of every decode source that equals the write-back ID.
- R7: After the execute instruction's own write-back, the pending flag is clear and the same source no longer stalls.
- R8: A write-back to a non-zero decode source that is not blocked by a pending execute write asserts that source's forward select with stall low.
- R9: flush clears the pending flag, so stall is low in the next cycle. An ex_enter in the flush cycle is discarded.
- R10: For "add x1,x5,x0; add x1,x6,x0; add x7,x1,x0" with x5≠x6, the third instruction reads the value of x6, never the value of x5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Squash the pipeline (branch or exception) |
| ex_enter | input | 1 | The decode instruction moves into execute at this edge |
| dec_wr | input | 1 | The decode instruction writes a register |
| dec_rd | input | AW | Decode destination register ID |
| dec_rs1 | input | AW | Decode first source register ID |
| dec_rs2 | input | AW | Decode second source register ID |
| wb_vld | input | 1 | A register write-back happens this cycle |
| wb_rd | input | AW | Write-back register ID |
| stall | output | 1 | Hold decode this cycle |
| fwd_rs1 | output | 1 | Take source 1 from the write-back path |
| fwd_rs2 | output | 1 | Take source 2 from the write-back path |

## Verification
The bench goes after the same-destination write in the first execute cycle. A tracker that matched only on register ID would drop stall there and forward the older value, and the modelled register file would then give x7 the value of x5. It also checks that stall falls in the very cycle of the own write-back, with both sources forwarded. A design that cleared the flag one cycle late would waste a cycle there, and one that cleared it early would forward stale data. Flush arriving together with an entering instruction, destinations of x0, and sources of x0 with a write-back to x0 show whether the tracker invents hazards or forwards that should not exist.

// File: rtl/hazard_ctl.sv
module hazard_ctl #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          ex_enter,
  input  logic          dec_wr,
  input  logic [AW-1:0] dec_rd,
  input  logic [AW-1:0] dec_rs1,
  input  logic [AW-1:0] dec_rs2,
  input  logic          wb_vld,
  input  logic [AW-1:0] wb_rd,
  output logic          stall,
  output logic          fwd_rs1,
  output logic          fwd_rs2
);
  localparam logic [AW-1:0] ZERO = '0;

  logic          pend_q, first_q;
  logic [AW-1:0] ex_rd_q;
  logic          own_wb, hz1, hz2;

  // execute-stage state: the write owed by the occupant, and its first cycle
  assign own_wb = pend_q && !first_q && wb_vld && (wb_rd == ex_rd_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      first_q <= 1'b0;
      ex_rd_q <= ZERO;
    end else if (flush) begin
      pend_q  <= 1'b0;
      first_q <= 1'b0;
    end else if (ex_enter) begin
      pend_q  <= dec_wr && (dec_rd != ZERO);
      first_q <= 1'b1;
      ex_rd_q <= dec_rd;
    end else begin
      first_q <= 1'b0;
      if (own_wb) pend_q <= 1'b0;
    end
  end

  assign hz1 = pend_q && !own_wb && (dec_rs1 != ZERO) && (dec_rs1 == ex_rd_q);
  assign hz2 = pend_q && !own_wb && (dec_rs2 != ZERO) && (dec_rs2 == ex_rd_q);

  assign stall   = hz1 || hz2;
  assign fwd_rs1 = wb_vld && (dec_rs1 != ZERO) && (dec_rs1 == wb_rd) && !hz1;
  assign fwd_rs2 = wb_vld && (dec_rs2 != ZERO) && (dec_rs2 == wb_rd) && !hz2;

  // R1
  always_ff @(posedge clk) begin
    if (!rst_n) reset_quiet_chk: assert (!stall && !fwd_rs1 && !fwd_rs2);
  end

  // R2
  set_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_enter && !flush && dec_wr && dec_rd != ZERO) |=> pend_q);

  // R3
  no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_enter && !flush && (!dec_wr || dec_rd == ZERO)) |=> !stall);

  // R4
  always_comb begin
    if (rst_n) x0_src_chk: assert (!((fwd_rs1 || stall) && dec_rs1 == ZERO && dec_rs2 == ZERO) && !(fwd_rs1 && dec_rs1 == ZERO) && !(fwd_rs2 && dec_rs2 == ZERO));
  end

  // R5
  first_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && first_q && !flush && !ex_enter) |=> pend_q);

  // R9
  flush_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!pend_q && !stall));
endmodule

// File: tb/sim_hazard_ctl.sv
module sim_hazard_ctl;
  localparam int AW = 5;
  logic clk = 1'b0, rst_n = 1'b0;
  logic flush = 0, ex_enter = 0, dec_wr = 0, wb_vld = 0;
  logic [AW-1:0] dec_rd = 0, dec_rs1 = 0, dec_rs2 = 0, wb_rd = 0;
  logic stall, fwd_rs1, fwd_rs2;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  hazard_ctl #(.AW(AW)) u0 (.clk, .rst_n, .flush, .ex_enter, .dec_wr, .dec_rd,
    .dec_rs1, .dec_rs2, .wb_vld, .wb_rd, .stall, .fwd_rs1, .fwd_rs2);

  function automatic logic [31:0] v(bit en, bit wr, int rd, int s1, int s2,
                                    bit wv, int wr_id, bit fl, bit st, bit f1, bit f2, int rq);
    return {en, wr, rd[4:0], s1[4:0], s2[4:0], wv, wr_id[4:0], fl, st, f1, f2, rq[3:0]};
  endfunction

  // enter wr rd rs1 rs2 wbv wbrd flush | stall f1 f2 | req
  localparam int NV = 17;
  localparam logic [31:0] VEC [NV] = '{
    v(1,1,1,0,0, 0,0,0, 0,0,0, 2),  // R2 issue writer of x1
    v(0,0,0,1,0, 1,1,0, 1,0,0, 5),  // R5 older write to x1 in first cycle
    v(0,0,0,1,0, 0,0,0, 1,0,0, 2),  // R2 still pending
    v(1,1,3,1,1, 1,1,0, 0,1,1, 6),  // R6 own write-back, both sources forwarded
    v(0,0,0,2,4, 1,2,0, 0,1,0, 8),  // R8 unrelated write-back forwarded
    v(0,0,0,0,3, 0,0,0, 1,0,0, 2),  // R2 rs2 hazard on x3
    v(0,0,0,0,0, 1,0,0, 0,0,0, 4),  // R4 x0 sources
    v(1,1,5,3,0, 0,0,1, 1,0,0, 9),  // R9 flush with entering instruction
    v(0,0,0,3,5, 0,0,0, 0,0,0, 9),  // R9 nothing pending after flush
    v(1,1,0,0,0, 0,0,0, 0,0,0, 3),  // R3 destination x0
    v(0,0,0,0,0, 0,0,0, 0,0,0, 3),  // R3
    v(1,0,7,0,0, 0,0,0, 0,0,0, 3),  // R3 non-writing instruction
    v(0,0,0,7,7, 0,0,0, 0,0,0, 3),  // R3 no stall on x7
    v(1,1,9,0,0, 0,0,0, 0,0,0, 2),  // R2 writer of x9
    v(0,0,0,0,0, 0,0,0, 0,0,0, 2),  // first cycle, idle decode
    v(0,0,0,0,0, 1,9,0, 0,0,0, 7),  // R7 own write-back
    v(0,0,0,9,0, 0,0,0, 0,0,0, 7)   // R7 flag cleared
  };

  task automatic chk(string tag, logic [2:0] got, logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: {stall,f1,f2} got=%b exp=%b", tag, got, exp);
    end
  endtask

  task automatic idle();
    ex_enter = 0; dec_wr = 0; dec_rd = 0; dec_rs1 = 0; dec_rs2 = 0;
    wb_vld = 0; wb_rd = 0; flush = 0;
  endtask

  logic [31:0] rf [32];
  logic [31:0] wb_data, t2;
  bit issued;

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog: got=hang exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle();
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    chk("R1 reset", {stall, fwd_rs1, fwd_rs2}, 3'b000);
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {ex_enter, dec_wr, dec_rd, dec_rs1, dec_rs2, wb_vld, wb_rd, flush} = VEC[i][31:7];
      #1;
      chk($sformatf("R%0d row %0d", VEC[i][3:0], i), {stall, fwd_rs1, fwd_rs2}, VEC[i][6:4]);
    end

    // R1: reset in the middle clears a pending write
    @(negedge clk); idle(); ex_enter = 1; dec_wr = 1; dec_rd = 12;
    @(negedge clk); idle(); dec_rs1 = 12; #1;
    chk("R2 pending x12", {stall, fwd_rs1, fwd_rs2}, 3'b100);
    rst_n = 0; #1;
    chk("R1 async reset", {stall, fwd_rs1, fwd_rs2}, 3'b000);
    @(negedge clk); rst_n = 1; #1;
    chk("R1 after reset", {stall, fwd_rs1, fwd_rs2}, 3'b000);

    // R10: same-destination pair then a reader, with register file stub
    for (int r = 0; r < 32; r++) rf[r] = 32'h0;
    rf[5] = 32'h11; rf[6] = 32'h22;
    t2 = 32'hdead; issued = 0;
    @(negedge clk); idle(); ex_enter = 1; dec_wr = 1; dec_rd = 1; dec_rs1 = 5;
    @(negedge clk); idle(); ex_enter = 1; dec_wr = 1; dec_rd = 1; dec_rs1 = 6;
    @(negedge clk); idle(); dec_wr = 1; dec_rd = 7; dec_rs1 = 1;
    wb_vld = 1; wb_rd = 1; wb_data = rf[5]; #1;
    if (!stall) begin t2 = fwd_rs1 ? wb_data : rf[1]; issued = 1; end
    ex_enter = !stall;
    @(posedge clk); rf[1] = wb_data;
    @(negedge clk); ex_enter = 0;
    wb_vld = 1; wb_rd = 1; wb_data = rf[6]; #1;
    if (!issued) begin
      if (!stall) begin t2 = fwd_rs1 ? wb_data : rf[1]; issued = 1; end
      ex_enter = !stall;
    end
    @(posedge clk); rf[1] = wb_data;
    checks++;
    if (t2 !== 32'h22) begin
      fails++;
      $display("FAIL R10 reader value got=%h exp=%h", t2, 32'h22);
    end
    @(negedge clk); idle(); flush = 1;
    @(negedge clk); idle(); #1;
    chk("R9 idle after flush", {stall, fwd_rs1, fwd_rs2}, 3'b000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule